// File: doc/BRIEF.md
# Reorder Buffer with Rename Indirection

This block sits between decode and the execution units of a pipeline that issues in order but lets instructions finish out of order. Each decoded instruction takes the next slot of a circular buffer. When an execution unit finishes, it returns the slot tag, the result and a fault flag, and the result is parked in that slot. The architectural register file is written only by the slot at the head of the buffer, and only once that slot has a result. Program-visible state therefore always matches a prefix of the program.

Source operands are found through a per-register mapping table rather than by searching the buffer. A clear pending bit means the architectural file is current. A set pending bit means the slot named in the table will produce the newest value. The lookup returns the value, either from the file, from a finished slot or from a result returned in the same cycle, or returns the tag to wait on.

When the head slot finishes with its fault flag set, nothing is written to the file. Every slot is discarded, every mapping falls back to the architectural file, and the faulting PC is reported as the redirect target.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `dec_ready` is 1, `dec_tag` is 0, every source lookup reports ready with value 0, and `ret_valid` and `flush_valid` are 0.
- R2: Each accepted decode (`dec_valid` with `dec_ready` high) takes the tag shown on `dec_tag`, and tags advance by one per accepted decode, wrapping from DEPTH-1 to 0.
- R3: With DEPTH slots occupied, `dec_ready` is 0. A decode presented while `dec_ready` is 0 is dropped and leaves no mapping behind.
- R4: A returned result is held in its own slot and is not written to the architectural file while an older slot is still unfinished. A lookup of that register still returns the slot's value as ready.
- R5: Slots retire strictly oldest first, at most one per cycle, and only when finished. `ret_valid`, `ret_wr`, `ret_dst` and `ret_value` show a retirement one clock edge after the cycle in which it happens.
- R6: A lookup of a register whose newest producer is an unfinished slot returns `src_ready` 0 and that slot's tag on `src_tag`.
- R7: A result returned in the same cycle as a lookup that waits on that tag is passed straight through: `src_ready` 1 with the returned value.
- R8: When a slot retires, its destination mapping is cleared only if the mapping still names that slot. A younger writer of the same register keeps the register pending.
- R9: A finished head slot with the fault flag set retires nothing and empties the buffer. `flush_valid` pulses for one cycle with `flush_pc` set to that slot's PC, and the next accepted decode receives the faulting slot's tag.
- R10: After a flush, every register lookup reads the architectural file, which ignores results of the discarded slots.
- R11: A result returned with a tag that names no occupied slot changes no slot and no lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoded instruction requests a slot |
| dec_has_dst | input | 1 | Instruction writes a register |
| dec_dst | input | RW | Destination register |
| dec_pc | input | PCW | Instruction PC |
| dec_src | input | NSRC*RW | Source registers, source g in bits g*RW upward |
| dec_ready | output | 1 | A slot is free |
| dec_tag | output | IW | Tag the next accepted decode receives |
| src_ready | output | NSRC | Source value is available |
| src_value | output | NSRC*DW | Source values |
| src_tag | output | NSRC*IW | Producer tag when not ready |
| cmp_valid | input | 1 | Execution result returned |
| cmp_tag | input | IW | Slot of the returned result |
| cmp_value | input | DW | Returned value |
| cmp_fault | input | 1 | Instruction raised an exception |
| ret_valid | output | 1 | A slot retired (registered) |
| ret_wr | output | 1 | Retired slot wrote a register |
| ret_dst | output | RW | Retired destination |
| ret_value | output | DW | Retired value |
| flush_valid | output | 1 | Precise exception flush (registered pulse) |
| flush_pc | output | PCW | PC of the faulting instruction |

## Verification
The lookup outputs and `dec_ready`/`dec_tag` are combinational in the current state, so they are sampled two time units after the negative edge at which inputs change, before the next rising edge. A result returned in cycle n finishes its slot at the rising edge closing n; the head retires in cycle n+1 at the earliest, and the retirement and flush outputs are registered, so they show after the edge closing that cycle. A monitor therefore records every `ret_valid` and `flush_valid` at negative edges, and the ordering and count checks read that log after enough idle cycles have passed, rather than guessing a single cycle.

// File: rtl/irb_pkg.sv
package irb_pkg;
  // Action taken by the head slot in the current cycle.
  typedef enum logic [1:0] {
    HD_IDLE   = 2'd0,
    HD_RETIRE = 2'd1,
    HD_FAULT  = 2'd2
  } head_act_e;
endpackage

// File: rtl/irb_ring.sv
module irb_ring
  import irb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  parameter int RW    = 4,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_go,
  input  logic            alloc_has_dst,
  input  logic [RW-1:0]   alloc_dst,
  input  logic [PCW-1:0]  alloc_pc,
  input  logic            cmp_valid,
  input  logic [IW-1:0]   cmp_tag,
  input  logic [DW-1:0]   cmp_value,
  input  logic            cmp_fault,
  input  logic [NRD*IW-1:0] rd_tag,
  output logic [NRD-1:0]  rd_done,
  output logic [NRD*DW-1:0] rd_value,
  output logic [IW-1:0]   head,
  output logic [IW-1:0]   tail,
  output logic [CW-1:0]   cnt,
  output logic            full,
  output head_act_e       act,
  output logic            head_has_dst,
  output logic [RW-1:0]   head_dst,
  output logic [DW-1:0]   head_value,
  output logic [PCW-1:0]  head_pc
);

  // Control state with reset.
  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] done;

  // Payload storage without reset (RAM style).
  logic [RW-1:0]  dst_mem   [DEPTH];
  logic           wr_mem    [DEPTH];
  logic [PCW-1:0] pc_mem    [DEPTH];
  logic [DW-1:0]  val_mem   [DEPTH];
  logic           fault_mem [DEPTH];

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic cmp_hit;
  assign cmp_hit = cmp_valid && occ[cmp_tag];
  assign full    = (cnt == CW'(DEPTH));

  always_comb begin
    act = HD_IDLE;
    if (cnt != '0 && done[head])
      act = fault_mem[head] ? HD_FAULT : HD_RETIRE;
  end

  assign head_has_dst = wr_mem[head];
  assign head_dst     = dst_mem[head];
  assign head_value   = val_mem[head];
  assign head_pc      = pc_mem[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      occ  <= '0;
      done <= '0;
    end else if (act == HD_FAULT) begin
      occ  <= '0;
      done <= '0;
      tail <= head;
      cnt  <= '0;
    end else begin
      if (alloc_go) begin
        occ[tail]  <= 1'b1;
        done[tail] <= 1'b0;
        tail       <= step(tail);
      end
      if (cmp_hit)
        done[cmp_tag] <= 1'b1;
      if (act == HD_RETIRE) begin
        occ[head] <= 1'b0;
        head      <= step(head);
      end
      cnt <= cnt + CW'(alloc_go) - CW'(act == HD_RETIRE);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_go) begin
      dst_mem[tail] <= alloc_dst;
      wr_mem[tail]  <= alloc_has_dst;
      pc_mem[tail]  <= alloc_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_hit) begin
      val_mem[cmp_tag]   <= cmp_value;
      fault_mem[cmp_tag] <= cmp_fault;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [IW-1:0] t;
    assign t                   = rd_tag[g*IW +: IW];
    assign rd_done[g]          = occ[t] && done[t];
    assign rd_value[g*DW +: DW] = val_mem[t];
  end

endmodule

// File: rtl/irb_map.sv
module irb_map #(
  parameter int NREG  = 16,
  parameter int DEPTH = 16,
  parameter int NRD   = 2,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              set_go,
  input  logic [RW-1:0]     set_reg,
  input  logic [IW-1:0]     set_tag,
  input  logic              clr_go,
  input  logic [RW-1:0]     clr_reg,
  input  logic [IW-1:0]     clr_tag,
  input  logic [NRD*RW-1:0] rd_reg,
  output logic [NRD-1:0]    rd_pend,
  output logic [NRD*IW-1:0] rd_tag
);

  logic [NREG-1:0] pend;
  logic [IW-1:0]   tag_mem [NREG];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend <= '0;
    end else begin
      if (clr_go && pend[clr_reg] && tag_mem[clr_reg] == clr_tag)
        pend[clr_reg] <= 1'b0;
      if (set_go)
        pend[set_reg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_go)
      tag_mem[set_reg] <= set_tag;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [RW-1:0] r;
    assign r                  = rd_reg[g*RW +: RW];
    assign rd_pend[g]         = pend[r];
    assign rd_tag[g*IW +: IW] = pend[r] ? tag_mem[r] : '0;
  end

endmodule

// File: rtl/irb_archfile.sv
module irb_archfile #(
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int NRD   = 2,
  localparam int RW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [RW-1:0]     wr_reg,
  input  logic [DW-1:0]     wr_value,
  input  logic [NRD*RW-1:0] rd_reg,
  output logic [NRD*DW-1:0] rd_value
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_go) begin
      regs[wr_reg] <= wr_value;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_value[g*DW +: DW] = regs[rd_reg[g*RW +: RW]];
  end

endmodule

// File: rtl/irb_operand.sv
module irb_operand #(
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          pend,
  input  logic [IW-1:0] tag,
  input  logic          slot_done,
  input  logic [DW-1:0] slot_value,
  input  logic [DW-1:0] arch_value,
  input  logic          cmp_valid,
  input  logic [IW-1:0] cmp_tag,
  input  logic [DW-1:0] cmp_value,
  output logic          ready,
  output logic [DW-1:0] value,
  output logic [IW-1:0] wait_tag
);

  always_comb begin
    ready    = 1'b1;
    value    = arch_value;
    wait_tag = '0;
    if (pend) begin
      wait_tag = tag;
      if (slot_done) begin
        value = slot_value;
      end else if (cmp_valid && cmp_tag == tag) begin
        value = cmp_value;
      end else begin
        ready = 1'b0;
        value = '0;
      end
    end
  end

endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf
  import irb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  parameter int NSRC  = 2,
  localparam int IW   = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dec_valid,
  input  logic               dec_has_dst,
  input  logic [RW-1:0]      dec_dst,
  input  logic [PCW-1:0]     dec_pc,
  input  logic [NSRC*RW-1:0] dec_src,
  output logic               dec_ready,
  output logic [IW-1:0]      dec_tag,
  output logic [NSRC-1:0]    src_ready,
  output logic [NSRC*DW-1:0] src_value,
  output logic [NSRC*IW-1:0] src_tag,
  input  logic               cmp_valid,
  input  logic [IW-1:0]      cmp_tag,
  input  logic [DW-1:0]      cmp_value,
  input  logic               cmp_fault,
  output logic               ret_valid,
  output logic               ret_wr,
  output logic [RW-1:0]      ret_dst,
  output logic [DW-1:0]      ret_value,
  output logic               flush_valid,
  output logic [PCW-1:0]     flush_pc
);

  logic [IW-1:0]      head_q, tail_q;
  logic [CW-1:0]      cnt_q;
  logic               full;
  head_act_e          act;
  logic               hd_wr;
  logic [RW-1:0]      hd_dst;
  logic [DW-1:0]      hd_value;
  logic [PCW-1:0]     hd_pc;
  logic               alloc_go;
  logic               retire_go;
  logic               fault_go;
  logic [NSRC-1:0]    map_pend;
  logic [NSRC*IW-1:0] map_tag;
  logic [NSRC-1:0]    slot_done;
  logic [NSRC*DW-1:0] slot_value;
  logic [NSRC*DW-1:0] arch_value;

  assign dec_ready = !full;
  assign dec_tag   = tail_q;
  assign alloc_go  = dec_valid && !full;
  assign retire_go = (act == HD_RETIRE);
  assign fault_go  = (act == HD_FAULT);

  irb_ring #(
    .DEPTH(DEPTH), .DW(DW), .PCW(PCW), .RW(RW), .NRD(NSRC)
  ) u_ring (
    .clk(clk), .rst(rst),
    .alloc_go(alloc_go), .alloc_has_dst(dec_has_dst),
    .alloc_dst(dec_dst), .alloc_pc(dec_pc),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .cmp_value(cmp_value), .cmp_fault(cmp_fault),
    .rd_tag(map_tag), .rd_done(slot_done), .rd_value(slot_value),
    .head(head_q), .tail(tail_q), .cnt(cnt_q), .full(full), .act(act),
    .head_has_dst(hd_wr), .head_dst(hd_dst),
    .head_value(hd_value), .head_pc(hd_pc)
  );

  irb_map #(
    .NREG(NREG), .DEPTH(DEPTH), .NRD(NSRC)
  ) u_map (
    .clk(clk), .rst(rst), .flush(fault_go),
    .set_go(alloc_go && dec_has_dst), .set_reg(dec_dst), .set_tag(tail_q),
    .clr_go(retire_go && hd_wr), .clr_reg(hd_dst), .clr_tag(head_q),
    .rd_reg(dec_src), .rd_pend(map_pend), .rd_tag(map_tag)
  );

  irb_archfile #(
    .NREG(NREG), .DW(DW), .NRD(NSRC)
  ) u_arch (
    .clk(clk), .rst(rst),
    .wr_go(retire_go && hd_wr), .wr_reg(hd_dst), .wr_value(hd_value),
    .rd_reg(dec_src), .rd_value(arch_value)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irb_operand #(.DW(DW), .IW(IW)) u_op (
      .pend(map_pend[g]),
      .tag(map_tag[g*IW +: IW]),
      .slot_done(slot_done[g]),
      .slot_value(slot_value[g*DW +: DW]),
      .arch_value(arch_value[g*DW +: DW]),
      .cmp_valid(cmp_valid),
      .cmp_tag(cmp_tag),
      .cmp_value(cmp_value),
      .ready(src_ready[g]),
      .value(src_value[g*DW +: DW]),
      .wait_tag(src_tag[g*IW +: IW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid   <= 1'b0;
      ret_wr      <= 1'b0;
      ret_dst     <= '0;
      ret_value   <= '0;
      flush_valid <= 1'b0;
      flush_pc    <= '0;
    end else begin
      ret_valid   <= retire_go;
      ret_wr      <= retire_go && hd_wr;
      flush_valid <= fault_go;
      if (retire_go) begin
        ret_dst   <= hd_dst;
        ret_value <= hd_value;
      end
      if (fault_go)
        flush_pc <= hd_pc;
    end
  end

endmodule

// File: rtl/irb_check.sv
module irb_check #(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] head_q,
  input logic [IW-1:0] tail_q,
  input logic [CW-1:0] cnt_q,
  input logic          alloc_go,
  input logic          retire_go,
  input logic          fault_go,
  input logic          ret_valid,
  input logic          flush_valid
);

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // R1: the first cycle after reset sees an empty buffer
  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_q == '0 && !ret_valid && !flush_valid));

  // R2: each accepted decode moves the tail by one slot
  assert_tail_step_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_go && !fault_go) |=> (tail_q == nxt($past(tail_q))));

  // R3: occupancy never exceeds the buffer depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  // R5: a retirement moves the head by exactly one slot
  assert_head_step_R5: assert property (@(posedge clk) disable iff (rst)
    retire_go |=> (head_q == nxt($past(head_q))));

  // R5: retire and flush reports never coincide
  assert_one_event_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ret_valid, flush_valid}));

  // R9: a flush report always sees an empty buffer
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (cnt_q == '0));

endmodule

bind inorder_retire_buf irb_check #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .head_q(head_q), .tail_q(tail_q), .cnt_q(cnt_q),
  .alloc_go(alloc_go), .retire_go(retire_go), .fault_go(fault_go),
  .ret_valid(ret_valid), .flush_valid(flush_valid)
);

// File: tb/sim_inorder_retire_buf.sv
module sim_inorder_retire_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16, NREG = 16, DW = 32, PCW = 32, NSRC = 2;
  localparam int IW = 4, RW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic dec_valid = 0, dec_has_dst = 0;
  logic [RW-1:0] dec_dst = '0;
  logic [PCW-1:0] dec_pc = '0;
  logic [NSRC*RW-1:0] dec_src = '0;
  logic dec_ready;
  logic [IW-1:0] dec_tag;
  logic [NSRC-1:0] src_ready;
  logic [NSRC*DW-1:0] src_value;
  logic [NSRC*IW-1:0] src_tag;
  logic cmp_valid = 0, cmp_fault = 0;
  logic [IW-1:0] cmp_tag = '0;
  logic [DW-1:0] cmp_value = '0;
  logic ret_valid, ret_wr, flush_valid;
  logic [RW-1:0] ret_dst;
  logic [DW-1:0] ret_value;
  logic [PCW-1:0] flush_pc;

  inorder_retire_buf #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .PCW(PCW), .NSRC(NSRC)) u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_has_dst(dec_has_dst),
    .dec_dst(dec_dst), .dec_pc(dec_pc), .dec_src(dec_src), .dec_ready(dec_ready),
    .dec_tag(dec_tag), .src_ready(src_ready), .src_value(src_value), .src_tag(src_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value), .cmp_fault(cmp_fault),
    .ret_valid(ret_valid), .ret_wr(ret_wr), .ret_dst(ret_dst), .ret_value(ret_value),
    .flush_valid(flush_valid), .flush_pc(flush_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Retirement / flush log, sampled at negative edges.
  int n_ret = 0, n_flush = 0;
  logic [RW-1:0] log_dst [64];
  logic [DW-1:0] log_val [64];
  logic [PCW-1:0] seen_pc = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ret_valid && ret_wr && n_ret < 64) begin
        log_dst[n_ret] = ret_dst;
        log_val[n_ret] = ret_value;
      end
      if (ret_valid) n_ret++;
      if (flush_valid) begin n_flush++; seen_pc = flush_pc; end
    end
  end

  // Vector: dec_v, has_dst, dst[4], src[4], cmp_v, cmp_tag[4], cmp_val[16], exp_rdy, exp_data[16], pad[16]
  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    {1'b1,1'b1,4'd1,4'd1,1'b0,4'd0,16'h0000,1'b1,16'h0000,16'h0}, // R6 unmapped r1 reads file
    {1'b1,1'b1,4'd2,4'd1,1'b0,4'd0,16'h0000,1'b0,16'h0000,16'h0}, // R6 r1 waits on tag 0
    {1'b1,1'b1,4'd1,4'd2,1'b1,4'd1,16'h0022,1'b1,16'h0022,16'h0}, // R7 bypass tag 1
    {1'b1,1'b1,4'd3,4'd2,1'b0,4'd0,16'h0000,1'b1,16'h0022,16'h0}, // R4 finished slot value
    {1'b0,1'b0,4'd0,4'd1,1'b1,4'd0,16'h0011,1'b0,16'h0002,16'h0}, // R6 r1 waits on tag 2
    {1'b0,1'b0,4'd0,4'd1,1'b1,4'd2,16'h0033,1'b1,16'h0033,16'h0}, // R7 bypass tag 2
    {1'b0,1'b0,4'd0,4'd1,1'b0,4'd0,16'h0000,1'b1,16'h0033,16'h0}, // R8 r1 still mapped to tag 2
    {1'b0,1'b0,4'd0,4'd2,1'b0,4'd0,16'h0000,1'b1,16'h0022,16'h0}, // R5 r2 retired to file
    {1'b0,1'b0,4'd0,4'd3,1'b0,4'd0,16'h0000,1'b0,16'h0003,16'h0}, // R6 r3 waits on tag 3
    {1'b0,1'b0,4'd0,4'd1,1'b0,4'd0,16'h0000,1'b1,16'h0033,16'h0}  // R5 r1 retired to file
  };

  task automatic drive_idle();
    dec_valid = 0; dec_has_dst = 0; cmp_valid = 0; cmp_fault = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_src(input logic [RW-1:0] r, input bit rdy, input logic [DW-1:0] data, input string req);
    dec_src = {NSRC{r}};
    #2;
    for (int g = 0; g < NSRC; g++) begin
      chk(src_ready[g] == rdy, req, src_ready[g], rdy);
      if (rdy) chk(src_value[g*DW +: DW] == data, req, src_value[g*DW +: DW], data);
      else     chk(src_tag[g*IW +: IW] == data[IW-1:0], req, src_tag[g*IW +: IW], data[IW-1:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done_flag) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check_src(4'd5, 1'b1, '0, "R1 reset lookup");
    chk(dec_ready == 1'b1, "R1 dec_ready", dec_ready, 1);
    chk(dec_tag == 0, "R1 dec_tag", dec_tag, 0);
    chk(!ret_valid && !flush_valid, "R1 no events", {ret_valid, flush_valid}, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      v = VEC[i];
      dec_valid = v[63]; dec_has_dst = v[62]; dec_dst = v[61:58];
      dec_pc = PCW'(32'h100 + 4 * i);
      cmp_valid = v[53]; cmp_tag = v[52:49]; cmp_value = DW'(v[48:33]); cmp_fault = 0;
      check_src(v[57:54], v[32], DW'(v[31:16]), $sformatf("R6 R7 R8 table row %0d", i));
      if (v[63]) chk(dec_tag == IW'(i), "R2 tag order", dec_tag, i);
      tick();
    end
    drive_idle();
    tick();
    chk(n_ret == 3, "R5 retire count", n_ret, 3);
    chk(log_dst[0] == 1 && log_val[0] == 32'h11, "R5 first retire", log_val[0], 32'h11);
    chk(log_dst[1] == 2 && log_val[1] == 32'h22, "R5 second retire", log_val[1], 32'h22);
    chk(log_dst[2] == 1 && log_val[2] == 32'h33, "R5 third retire", log_val[2], 32'h33);

    // R11 stray completion to unoccupied tag 5
    cmp_valid = 1; cmp_tag = 4'd5; cmp_value = 32'h99; tick(); drive_idle();
    dec_valid = 1; dec_has_dst = 1; dec_dst = 4'd4; dec_pc = 32'h180; #2;
    chk(dec_tag == 4, "R2 tag 4", dec_tag, 4); tick();
    dec_dst = 4'd5; dec_pc = 32'h184; #2;
    chk(dec_tag == 5, "R2 tag 5", dec_tag, 5); tick();
    drive_idle();
    check_src(4'd5, 1'b0, 32'd5, "R11 stray result ignored");
    tick();

    // R4 younger results held while head unfinished
    cmp_valid = 1; cmp_tag = 4'd5; cmp_value = 32'h66; tick();
    cmp_tag = 4'd4; cmp_value = 32'h55; tick();
    drive_idle(); repeat (3) tick();
    chk(n_ret == 3, "R4 no retire past unfinished head", n_ret, 3);
    check_src(4'd5, 1'b1, 32'h66, "R4 value held in slot");
    check_src(4'd4, 1'b1, 32'h55, "R4 value held in slot");
    tick();
    cmp_valid = 1; cmp_tag = 4'd3; cmp_value = 32'h44; tick();
    drive_idle(); repeat (5) tick();
    chk(n_ret == 6, "R5 drained count", n_ret, 6);
    chk(log_dst[3] == 3 && log_val[3] == 32'h44, "R5 order tag 3", log_val[3], 32'h44);
    chk(log_dst[4] == 4 && log_val[4] == 32'h55, "R5 order tag 4", log_val[4], 32'h55);
    chk(log_dst[5] == 5 && log_val[5] == 32'h66, "R5 order tag 5", log_val[5], 32'h66);
    check_src(4'd3, 1'b1, 32'h44, "R5 file updated");
    tick();

    // R2 wrap and R3 full
    for (int i = 0; i < DEPTH; i++) begin
      dec_valid = 1; dec_has_dst = (i == 1); dec_dst = 4'd8;
      dec_pc = PCW'(32'h200 + 4 * i);
      #2;
      chk(dec_ready == 1, "R3 ready while not full", dec_ready, 1);
      chk(dec_tag == IW'((6 + i) % DEPTH), "R2 tag wrap", dec_tag, (6 + i) % DEPTH);
      tick();
    end
    dec_valid = 1; dec_has_dst = 1; dec_dst = 4'd7; dec_pc = 32'h300; #2;
    chk(dec_ready == 0, "R3 full", dec_ready, 0);
    tick(); drive_idle();
    check_src(4'd7, 1'b1, 32'h0, "R3 dropped decode left no mapping");
    check_src(4'd8, 1'b0, 32'd7, "R6 r8 waits on tag 7");
    tick();

    // R9 precise exception at head tag 6
    cmp_valid = 1; cmp_tag = 4'd7; cmp_value = 32'h77; tick();
    cmp_tag = 4'd6; cmp_fault = 1; cmp_value = 32'h0; tick();
    drive_idle(); repeat (3) tick();
    chk(n_flush == 1, "R9 one flush", n_flush, 1);
    chk(seen_pc == 32'h200, "R9 flush pc", seen_pc, 32'h200);
    chk(n_ret == 6, "R9 nothing retired", n_ret, 6);
    #2;
    chk(dec_ready == 1, "R9 buffer empty", dec_ready, 1);
    chk(dec_tag == 6, "R9 next tag is faulting tag", dec_tag, 6);
    check_src(4'd8, 1'b1, 32'h0, "R10 flushed mapping reads file");
    check_src(4'd1, 1'b1, 32'h33, "R10 file intact");

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule